// File: doc/BRIEF.md
# Shared Local Bus Ownership Agent

This block is the bus-side agent of an internal transaction engine that shares one local memory bus with a single external master. When the engine posts work, the agent raises an active-low request line. It runs transfers only while an active-low grant input is held low. When the external master pulls an active-low release input low, the agent hands the bus over by taking its request high for exactly one cycle and then lowering it again.

The time of that one-cycle drop-out depends on what the agent is doing when release arrives. If no transfer is running, the request goes high in the next cycle. If a transfer is running, the agent finishes it first, and the request goes high in the second cycle after the cycle in which the engine signals completion. Pending work that a hand-over or a missing grant holds back is counted and kept. It starts once grant and request are both asserted again. When no external master exists, grant may be tied low for good. The transaction engine sees an owns-bus flag and a one-cycle start pulse for each transfer it may launch.

Top module: `lbus_own_ctrl`

## Requirements
- R1: After reset, req_n is high, owns_bus is low and xfer_go is low. Release has no effect on req_n before the first xfer_pend strobe has been seen.
- R2: req_n goes low in the cycle after the first xfer_pend strobe. After that it is high only during hand-over drop-outs.
- R3: xfer_go is high for one cycle only when work is pending, no transfer is running, req_n and grant_n are low, release_n is high and no hand-over is under way. A transfer runs from the cycle after xfer_go until an xfer_done strobe. Grant tied low throughout is a supported case.
- R4: If release_n is sampled low while req_n is low, no transfer is running and release was seen high since the last drop-out, req_n is high in the next cycle.
- R5: If release_n is sampled low while a transfer is running, req_n goes high in the second cycle after the cycle with xfer_done. Release in the same cycle as xfer_done counts as running.
- R6: Each drop-out lasts exactly one cycle. release_n held low through the drop-out and the cycle after it causes no second drop-out. A new hand-over needs release_n to have been seen high first.
- R7: While grant_n is high, xfer_go stays low. A pending transfer blocked by a hand-over is kept and starts in the first cycle where grant_n is low again.
- R8: owns_bus is high exactly when req_n and grant_n are both low and the agent is not in the post-transfer gap or the drop-out cycle of a hand-over.
- R9: Each xfer_pend strobe yields one xfer_go. Pending work is counted up to 2^PEND_W-1, and further strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_n | input | 1 | Bus grant, active low |
| release_n | input | 1 | External master's bid for the bus, active low |
| xfer_pend | input | 1 | One-cycle strobe: the engine has one more transfer to run |
| xfer_done | input | 1 | One-cycle strobe: the running transfer has finished |
| req_n | output | 1 | Bus request, active low, registered |
| owns_bus | output | 1 | The engine may drive the bus this cycle |
| xfer_go | output | 1 | One-cycle start of a pending transfer |

## Verification
The bench sweeps transfer lengths against release arriving before, on, and after the completion cycle. A design that counted the gap from the release edge, or that treated release coinciding with completion as idle, would take req_n high a cycle or more early. In every case release is held low through the drop-out and the cycle after it, so a design that re-triggered on a level would show a second drop-out. Other runs check the following: a transfer blocked by release must survive and start only when grant returns, release before any request must do nothing, and strobe bursts longer than the counter must produce exactly the saturated number of starts. Getting these wrong would show up as a lost, duplicated or premature xfer_go.

// File: rtl/lbus_own_pkg.sv
package lbus_own_pkg;
   typedef enum logic [1:0] {
      HS_OWN   = 2'd0,
      HS_ARMED = 2'd1,
      HS_GAP   = 2'd2,
      HS_DROP  = 2'd3
   } hs_e;
endpackage

// File: rtl/lbus_hs_fsm.sv
module lbus_hs_fsm
   import lbus_own_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic release_n,
   input  logic req_on,
   input  logic busy,
   input  logic done,
   output hs_e  hand_q,
   output hs_e  hand_d,
   output logic rel_armed_q
);
   logic trig;
   logic rel_armed_d;

   assign trig = !release_n && rel_armed_q && req_on;

   always_comb begin
      hand_d = hand_q;
      unique case (hand_q)
         HS_OWN: begin
            if (trig) begin
               if (!busy)     hand_d = HS_DROP;
               else if (done) hand_d = HS_GAP;
               else           hand_d = HS_ARMED;
            end
         end
         HS_ARMED: if (done) hand_d = HS_GAP;
         HS_GAP:   hand_d = HS_DROP;
         HS_DROP:  hand_d = HS_OWN;
         default:  hand_d = HS_OWN;
      endcase
   end

   always_comb begin
      rel_armed_d = rel_armed_q;
      if (hand_d == HS_DROP && hand_q != HS_DROP) rel_armed_d = 1'b0;
      else if (release_n)                          rel_armed_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hand_q      <= HS_OWN;
         rel_armed_q <= 1'b1;
      end else begin
         hand_q      <= hand_d;
         rel_armed_q <= rel_armed_d;
      end
   end
endmodule

// File: rtl/lbus_pend_ctr.sv
module lbus_pend_ctr #(
   parameter int PEND_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic nonzero
);
   localparam logic [PEND_W-1:0] FULL = {PEND_W{1'b1}};

   generate
      if (PEND_W < 1) begin : g_bad_width
         $error("lbus_pend_ctr: PEND_W must be at least 1");
      end else if (PEND_W == 1) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (inc) flag_q <= 1'b1;
            else if (dec) flag_q <= 1'b0;
         end
         assign nonzero = flag_q;
      end else begin : g_count
         logic [PEND_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (inc && !dec) begin
               if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
            end else if (dec && !inc) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign nonzero = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/lbus_xfer_track.sv
module lbus_xfer_track (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic done,
   output logic busy_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    busy_q <= 1'b0;
      else if (go)   busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
   end
endmodule

// File: rtl/lbus_own_ctrl.sv
module lbus_own_ctrl
   import lbus_own_pkg::*;
#(
   parameter int PEND_W       = 3,
   parameter int REQ_AT_RESET = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_n,
   input  logic release_n,
   input  logic xfer_pend,
   input  logic xfer_done,
   output logic req_n,
   output logic owns_bus,
   output logic xfer_go
);
   localparam logic UP_INIT = (REQ_AT_RESET != 0);

   generate
      if (REQ_AT_RESET != 0 && REQ_AT_RESET != 1) begin : g_bad_mode
         $error("lbus_own_ctrl: REQ_AT_RESET must be 0 or 1");
      end
   endgenerate

   hs_e  hand_q, hand_d;
   logic rel_armed_q;
   logic busy_q;
   logic pend_nz;
   logic req_up_q, req_up_d;
   logic req_n_q;

   lbus_hs_fsm u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .release_n  (release_n),
      .req_on     (!req_n_q),
      .busy       (busy_q),
      .done       (xfer_done),
      .hand_q     (hand_q),
      .hand_d     (hand_d),
      .rel_armed_q(rel_armed_q)
   );

   lbus_pend_ctr #(.PEND_W(PEND_W)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (xfer_pend),
      .dec    (xfer_go),
      .nonzero(pend_nz)
   );

   lbus_xfer_track u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (xfer_go),
      .done  (xfer_done),
      .busy_q(busy_q)
   );

   assign req_up_d = req_up_q | xfer_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_up_q <= UP_INIT;
         req_n_q  <= 1'b1;
      end else begin
         req_up_q <= req_up_d;
         req_n_q  <= !(req_up_d && hand_d != HS_DROP);
      end
   end

   assign xfer_go  = pend_nz && !busy_q && !req_n_q && !grant_n
                     && release_n && (hand_q == HS_OWN);
   assign owns_bus = !req_n_q && !grant_n
                     && (hand_q == HS_OWN || hand_q == HS_ARMED);
   assign req_n    = req_n_q;
endmodule

// File: rtl/lbus_own_chk.sv
module lbus_own_chk
   import lbus_own_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic grant_n,
   input logic release_n,
   input logic xfer_done,
   input logic req_n,
   input logic owns_bus,
   input logic xfer_go,
   input hs_e  hand_q,
   input logic busy_q,
   input logic rel_armed_q
);
   // R3: a start needs request, grant, quiet release and an idle engine
   assert_start_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |-> (!grant_n && !req_n && release_n && !busy_q));

   // R3: a start is followed by a running transfer
   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |=> busy_q);

   // R4: release while idle drops request next cycle
   assert_idle_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hand_q == HS_OWN && !release_n && rel_armed_q && !req_n && !busy_q)
      |=> req_n);

   // R5: completion during an armed hand-over: gap cycle, then drop-out
   assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hand_q == HS_ARMED && xfer_done) |=> (!req_n ##1 req_n));

   // R6: drop-out lasts one cycle
   assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_n) |=> !req_n);

   // R7: no start without grant
   assert_no_go_ungranted_R7: assert property (@(posedge clk) disable iff (!rst_n)
      grant_n |-> !xfer_go);

   // R8: ownership implies request and grant
   assert_owns_R8: assert property (@(posedge clk) disable iff (!rst_n)
      owns_bus |-> (!req_n && !grant_n));
endmodule

bind lbus_own_ctrl lbus_own_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .grant_n    (grant_n),
   .release_n  (release_n),
   .xfer_done  (xfer_done),
   .req_n      (req_n),
   .owns_bus   (owns_bus),
   .xfer_go    (xfer_go),
   .hand_q     (hand_q),
   .busy_q     (busy_q),
   .rel_armed_q(rel_armed_q)
);

// File: tb/sim_lbus_own_ctrl.sv
module sim_lbus_own_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gn = 1'b1, rn = 1'b1, pe = 1'b0, dn = 1'b0;
   logic req_n, owns_bus, xfer_go;
   int   checks = 0;
   int   errors = 0;
   bit   done_flag = 1'b0;

   always #4 clk = ~clk;

   lbus_own_ctrl #(.PEND_W(2), .REQ_AT_RESET(0)) u0 (
      .clk(clk), .rst_n(rst_n), .grant_n(gn), .release_n(rn),
      .xfer_pend(pe), .xfer_done(dn),
      .req_n(req_n), .owns_bus(owns_bus), .xfer_go(xfer_go)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   task automatic adv;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int gos;
      logic prev_go;
      repeat (3) adv();
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 req_n", req_n, 1'b1);
      chk("R1 owns_bus", owns_bus, 1'b0);
      chk("R1 xfer_go", xfer_go, 1'b0);
      // R1: release before any demand does nothing
      gn = 1'b0; rn = 1'b0;
      adv(); adv();
      rn = 1'b1; #1;
      chk("R1 req_n after early release", req_n, 1'b1);
      adv();
      // R2: first strobe raises request next cycle; R3 start
      pe = 1'b1; #1;
      adv();
      pe = 1'b0; #1;
      chk("R2 req_n low after strobe", req_n, 1'b0);
      chk("R3 go with grant tied", xfer_go, 1'b1);
      adv();
      dn = 1'b1; #1;
      chk("R3 no go while running", xfer_go, 1'b0);
      adv();
      dn = 1'b0;
      for (int k = 0; k < 4; k++) begin
         #1;
         chk("R2 request held", req_n, 1'b0);
         adv();
      end

      // R4/R5/R6/R8 sweep: transfer length vs release position
      for (int L = 1; L <= 4; L++) begin
         for (int dr = -(L - 1); dr <= 2; dr++) begin
            int dc, r, dd;
            bit bz;
            dc = 1 + L;
            r  = dc + dr;
            bz = (r <= dc);
            dd = bz ? dc + 2 : r + 1;
            for (int t = 0; t <= dd + 3; t++) begin
               pe = (t == 0);
               dn = (t == dc);
               rn = !(t >= r && t <= dd + 1);
               gn = 1'b0;
               #1;
               chk(bz ? "R5 req_n timing" : "R4 req_n timing", req_n, (t == dd));
               if (t == dd + 1) chk("R6 single drop-out", req_n, 1'b0);
               chk("R3 go timing", xfer_go, (t == 1));
               chk("R8 owns_bus", owns_bus, (t != dd) && !(bz && t == dd - 1));
               adv();
            end
         end
      end
      pe = 1'b0; dn = 1'b0; rn = 1'b1;
      adv();

      // R7: release blocks a pending start; start once grant returns
      for (int t = 0; t <= 9; t++) begin
         pe = (t == 0);
         rn = !(t >= 1 && t <= 2);
         gn = (t >= 2 && t <= 5);
         dn = (t == 7);
         #1;
         if (t == 1) chk("R3 release blocks go", xfer_go, 1'b0);
         if (t == 2) chk("R4 drop-out on blocked start", req_n, 1'b1);
         if (t >= 3 && t <= 5) chk("R7 no go without grant", xfer_go, 1'b0);
         if (t == 3) chk("R8 no ownership without grant", owns_bus, 1'b0);
         if (t == 6) chk("R7 kept start on grant", xfer_go, 1'b1);
         if (t >= 8) chk("R7 single start", xfer_go, 1'b0);
         adv();
      end
      dn = 1'b0;

      // R9: strobe bursts vs saturation at 3
      for (int n = 1; n <= 5; n++) begin
         gn = 1'b1;
         for (int s = 0; s < n; s++) begin
            pe = 1'b1; #1;
            chk("R7 no go while grant high", xfer_go, 1'b0);
            adv();
         end
         pe = 1'b0;
         gn = 1'b0;
         gos = 0;
         prev_go = 1'b0;
         for (int c = 0; c < 16; c++) begin
            dn = prev_go;
            #1;
            if (xfer_go) gos++;
            prev_go = xfer_go;
            adv();
         end
         dn = 1'b0;
         chk_int("R9 start count", gos, (n < 3) ? n : 3);
      end

      finish_run();
   end
endmodule